// File: doc/BRIEF.md
# Debug Link Command Decoder

This block sits between a byte-level serial transceiver and the execution engine of an on-chip debug core. It takes the received byte stream and turns it into commands. Some bytes load 16-bit words: the program counter, a hardware breakpoint address or an instruction word. Some return words: those three plus a fixed identification code. Others write or read an 8-bit control byte that selects the transfer mode, store a flag byte, or fire one-cycle strobes into the engine: start a memory transfer, step one register, execute the instruction word, resume, single-step or reset.

Responses go into a small ordered queue that the transceiver drains one entry at a time. An entry is either a data byte or a marker that tells the transceiver to emit a line break. A break from the host, a reset command or a halt reported by the engine leaves the block in a post-break condition. In that condition a program-counter read returns the stored value plus one. A disable command shuts the port until the next hardware reset.

Top module: `dbg_cmd_top`

## Requirements
- R1: After reset all register outputs and strobes are 0, `timersRun` is 1, `portOff` is 0 and `txValid` is 0.
- R2: A byte 0b1101xxss is followed by a high byte and a low byte. The word is visible the cycle after the low byte: ss=0 loads `pcOut`, ss=1 loads `bpOut`, ss=2 loads `irOut`, and ss=3 changes nothing. Bits 3:2 are ignored.
- R3: A byte 0b1111xxss queues two data bytes, high first: the PC for ss=0, the breakpoint for ss=1, the instruction word for ss=2 and the parameter `SIGNATURE` (default 0x9489) for ss=3. Bits 3:2 are ignored.
- R4: Three events set a post-break condition: a host break, a reset command or a core halt. While it is set, a PC read returns PC+1. A PC load or any execution strobe clears it.
- R5: A byte 0b1100xxxx followed by a data byte stores that byte in `ctlOut`. A byte 0b1110xxxx queues `ctlOut` as one data byte.
- R6: Any byte 0b01xxxxxx is stored in `flagOut`, and `timersRun` equals the inverse of flag bit 5.
- R7: Bytes 0x20, 0x21, 0x23, 0x30 and 0x31 each pulse one strobe for exactly the cycle after the byte is accepted. The strobes are `goMem`, `stepReg`, `execIr`, `resumeRun` and `stepOne`, in that order.
- R8: A byte 0b00xxx111 pulses `coreReset` and queues a data byte 0x00, then a break marker, then a data byte 0x55.
- R9: A host break (`rxBreak`) aborts any partly received command and queues data byte 0x55. A byte in the same cycle as a break is discarded.
- R10: A byte 0b00xxx110 sets `portOff`, which stays set until hardware reset. While it is set, received bytes and breaks have no effect.
- R11: Bytes 0b10xxxxxx and any 0b00xxxxxx byte not named in R7, R8 or R10 queue nothing and change no output.
- R12: A `coreHalt` pulse loads `corePc` into `pcOut` one cycle later, even over a PC load in the same cycle. It queues a break marker and then data byte 0x55.
- R13: Queue entries leave in order, one per cycle in which `txValid` and `txTake` are both high. While `txValid` is high and `txTake` is low, `txByte` and `txBreak` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | Received byte valid for one cycle |
| rxByte | input | 8 | Received byte |
| rxBreak | input | 1 | Host break detected, one cycle |
| txTake | input | 1 | Transceiver consumes the queue head |
| txValid | output | 1 | Queue head valid |
| txByte | output | 8 | Queue head data byte |
| txBreak | output | 1 | Queue head is a break marker |
| coreHalt | input | 1 | Engine halted, one-cycle pulse |
| corePc | input | 16 | PC reported by the engine on halt |
| pcOut | output | 16 | Program counter register |
| bpOut | output | 16 | Hardware breakpoint register |
| irOut | output | 16 | Instruction word register |
| ctlOut | output | 8 | Control byte (transfer mode) |
| flagOut | output | 8 | Last flag byte |
| timersRun | output | 1 | Timers keep running while halted |
| goMem | output | 1 | Start memory transfer strobe |
| stepReg | output | 1 | Single register transfer strobe |
| execIr | output | 1 | Execute instruction word strobe |
| resumeRun | output | 1 | Resume execution strobe |
| stepOne | output | 1 | Single-step strobe |
| coreReset | output | 1 | Core reset strobe |
| portOff | output | 1 | Debug port disabled |

## Verification
The bound checker watches several properties on every cycle:
- at most one engine strobe is active at a time;
- `portOff` never clears, and no strobe follows while it is set;
- the queue head holds while it is stalled;
- the queue never drops a response for lack of space;
- a halt always lands the reported PC.

The bench's scenarios cover what needs a full command sequence. That includes alias decoding of the index bits, high-before-low ordering of word replies, and the plus-one PC after each kind of break. It also includes abort of a half-received word, the ordering of the reset reply, and the silence after unknown opcodes and after disable.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  localparam int RSP_SLOTS = 5;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_HI,
    PS_LO,
    PS_CTL
  } parse_e;

  typedef struct packed {
    logic       capHi;
    logic       wrWord;
    logic       wrCtl;
    logic       wrFlag;
    logic       rdWord;
    logic       rdCtl;
    logic [1:0] sel;
    logic       brkSeen;
    logic       rstCmd;
    logic       goMem;
    logic       stepReg;
    logic       execIr;
    logic       resumeRun;
    logic       stepOne;
  } ctrlStrb_t;

  typedef struct packed {
    logic       brk;
    logic [7:0] data;
  } rspEntry_t;

  typedef rspEntry_t [RSP_SLOTS-1:0] rspList_t;

endpackage

// File: rtl/dbg_ctrl.sv
module dbg_ctrl
  import dbg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       rxBreak,
  output ctrlStrb_t  strb,
  output logic       portOff
);

  parse_e     st, stNext;
  logic [1:0] selQ, selNext;
  logic       offNext;

  always_comb begin
    strb     = '0;
    strb.sel = selQ;
    stNext   = st;
    selNext  = selQ;
    offNext  = portOff;
    if (!portOff) begin
      if (rxBreak) begin
        strb.brkSeen = 1'b1;
        stNext       = PS_IDLE;
      end else if (rxValid) begin
        case (st)
          PS_IDLE: begin
            strb.sel = rxByte[1:0];
            case (rxByte[7:6])
              2'b11: begin
                case (rxByte[5:4])
                  2'b00: stNext = PS_CTL;
                  2'b01: begin
                    stNext  = PS_HI;
                    selNext = rxByte[1:0];
                  end
                  2'b10: strb.rdCtl = 1'b1;
                  default: strb.rdWord = 1'b1;
                endcase
              end
              2'b01: strb.wrFlag = 1'b1;
              2'b00: begin
                if (rxByte[2:0] == 3'b111) begin
                  strb.rstCmd = 1'b1;
                end else if (rxByte[2:0] == 3'b110) begin
                  offNext = 1'b1;
                end else begin
                  case (rxByte[5:0])
                    6'h20: strb.goMem     = 1'b1;
                    6'h21: strb.stepReg   = 1'b1;
                    6'h23: strb.execIr    = 1'b1;
                    6'h30: strb.resumeRun = 1'b1;
                    6'h31: strb.stepOne   = 1'b1;
                    default: ;
                  endcase
                end
              end
              default: ;
            endcase
          end
          PS_HI: begin
            strb.capHi = 1'b1;
            stNext     = PS_LO;
          end
          PS_LO: begin
            strb.wrWord = 1'b1;
            stNext      = PS_IDLE;
          end
          default: begin
            strb.wrCtl = 1'b1;
            stNext     = PS_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= PS_IDLE;
      selQ    <= 2'd0;
      portOff <= 1'b0;
    end else begin
      st      <= stNext;
      selQ    <= selNext;
      portOff <= offNext;
    end
  end

endmodule

// File: rtl/dbg_regs.sv
module dbg_regs
  import dbg_pkg::*;
#(
  parameter logic [15:0] SIGNATURE = 16'h9489,
  parameter int          WORD_W    = 16,
  parameter int          BYTE_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              coreHalt,
  input  logic [WORD_W-1:0] corePc,
  output rspList_t          pushData,
  output logic [2:0]        pushCnt,
  output logic [WORD_W-1:0] pcOut,
  output logic [WORD_W-1:0] bpOut,
  output logic [WORD_W-1:0] irOut,
  output logic [BYTE_W-1:0] ctlOut,
  output logic [BYTE_W-1:0] flagOut,
  output logic              timersRun,
  output logic              goMem,
  output logic              stepReg,
  output logic              execIr,
  output logic              resumeRun,
  output logic              stepOne,
  output logic              coreReset
);

  localparam logic [7:0] SYNC_BYTE = 8'h55;

  logic [BYTE_W-1:0] hiByte;
  logic              afterBrk;
  logic [WORD_W-1:0] readVal;
  logic              anyExec;
  logic              pcLoad;
  logic              brkEvent;

  assign anyExec  = strb.goMem | strb.stepReg | strb.execIr | strb.resumeRun | strb.stepOne;
  assign pcLoad   = strb.wrWord && (strb.sel == 2'd0);
  assign brkEvent = strb.brkSeen | strb.rstCmd | coreHalt;
  assign timersRun = ~flagOut[5];

  always_comb begin
    case (strb.sel)
      2'd0:    readVal = pcOut + WORD_W'(afterBrk);
      2'd1:    readVal = bpOut;
      2'd2:    readVal = irOut;
      default: readVal = SIGNATURE;
    endcase
  end

  always_comb begin
    pushData = '0;
    pushCnt  = 3'd0;
    if (strb.rdWord) begin
      pushData[0] = '{brk: 1'b0, data: readVal[15:8]};
      pushData[1] = '{brk: 1'b0, data: readVal[7:0]};
      pushCnt     = 3'd2;
    end else if (strb.rdCtl) begin
      pushData[0] = '{brk: 1'b0, data: ctlOut};
      pushCnt     = 3'd1;
    end else if (strb.rstCmd) begin
      pushData[0] = '{brk: 1'b0, data: 8'h00};
      pushData[1] = '{brk: 1'b1, data: 8'h00};
      pushData[2] = '{brk: 1'b0, data: SYNC_BYTE};
      pushCnt     = 3'd3;
    end else if (strb.brkSeen) begin
      pushData[0] = '{brk: 1'b0, data: SYNC_BYTE};
      pushCnt     = 3'd1;
    end
    if (coreHalt) begin
      pushData[pushCnt]        = '{brk: 1'b1, data: 8'h00};
      pushData[pushCnt + 3'd1] = '{brk: 1'b0, data: SYNC_BYTE};
      pushCnt                  = pushCnt + 3'd2;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiByte    <= '0;
      afterBrk  <= 1'b0;
      pcOut     <= '0;
      bpOut     <= '0;
      irOut     <= '0;
      ctlOut    <= '0;
      flagOut   <= '0;
      goMem     <= 1'b0;
      stepReg   <= 1'b0;
      execIr    <= 1'b0;
      resumeRun <= 1'b0;
      stepOne   <= 1'b0;
      coreReset <= 1'b0;
    end else begin
      goMem     <= strb.goMem;
      stepReg   <= strb.stepReg;
      execIr    <= strb.execIr;
      resumeRun <= strb.resumeRun;
      stepOne   <= strb.stepOne;
      coreReset <= strb.rstCmd;
      if (strb.capHi) hiByte <= rxByte;
      if (strb.wrCtl) ctlOut <= rxByte;
      if (strb.wrFlag) flagOut <= rxByte;
      if (strb.wrWord) begin
        case (strb.sel)
          2'd1:    bpOut <= {hiByte, rxByte};
          2'd2:    irOut <= {hiByte, rxByte};
          default: ;
        endcase
      end
      if (coreHalt) pcOut <= corePc;
      else if (pcLoad) pcOut <= {hiByte, rxByte};
      if (brkEvent) afterBrk <= 1'b1;
      else if (pcLoad || anyExec) afterBrk <= 1'b0;
    end
  end

endmodule

// File: rtl/dbg_rsp_fifo.sv
module dbg_rsp_fifo
  import dbg_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  rspList_t  pushData,
  input  logic [2:0] pushCnt,
  input  logic      pop,
  output rspEntry_t head,
  output logic      notEmpty,
  output logic      dropped
);

  localparam int AW = $clog2(DEPTH);

  rspEntry_t     mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   count;
  logic [AW:0]   free;
  logic          accept;
  logic          doPop;

  assign free     = (AW+1)'(DEPTH) - count;
  assign accept   = (AW+1)'(pushCnt) <= free;
  assign dropped  = (pushCnt != 3'd0) && !accept;
  assign notEmpty = count != '0;
  assign doPop    = pop && notEmpty;
  assign head     = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (doPop) rdPtr <= rdPtr + AW'(1);
      if (accept) begin
        for (int i = 0; i < RSP_SLOTS; i++) begin
          if (i < int'(pushCnt)) mem[wrPtr + AW'(i)] <= pushData[i];
        end
        wrPtr <= wrPtr + AW'(pushCnt);
      end
      count <= count + (accept ? (AW+1)'(pushCnt) : '0) - (AW+1)'(doPop);
    end
  end

endmodule

// File: rtl/dbg_cmd_top.sv
module dbg_cmd_top
  import dbg_pkg::*;
#(
  parameter logic [15:0] SIGNATURE = 16'h9489,
  parameter int          RSP_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic        rxBreak,
  input  logic        txTake,
  output logic        txValid,
  output logic [7:0]  txByte,
  output logic        txBreak,
  input  logic        coreHalt,
  input  logic [15:0] corePc,
  output logic [15:0] pcOut,
  output logic [15:0] bpOut,
  output logic [15:0] irOut,
  output logic [7:0]  ctlOut,
  output logic [7:0]  flagOut,
  output logic        timersRun,
  output logic        goMem,
  output logic        stepReg,
  output logic        execIr,
  output logic        resumeRun,
  output logic        stepOne,
  output logic        coreReset,
  output logic        portOff
);

  ctrlStrb_t strb;
  rspList_t  pushData;
  logic [2:0] pushCnt;
  rspEntry_t head;
  logic      dropped;

  dbg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .rxBreak(rxBreak), .strb(strb), .portOff(portOff)
  );

  dbg_regs #(.SIGNATURE(SIGNATURE)) regs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte),
    .coreHalt(coreHalt), .corePc(corePc),
    .pushData(pushData), .pushCnt(pushCnt),
    .pcOut(pcOut), .bpOut(bpOut), .irOut(irOut), .ctlOut(ctlOut),
    .flagOut(flagOut), .timersRun(timersRun),
    .goMem(goMem), .stepReg(stepReg), .execIr(execIr),
    .resumeRun(resumeRun), .stepOne(stepOne), .coreReset(coreReset)
  );

  dbg_rsp_fifo #(.DEPTH(RSP_DEPTH)) fifo_i (
    .clk(clk), .rstN(rstN), .pushData(pushData), .pushCnt(pushCnt),
    .pop(txTake), .head(head), .notEmpty(txValid), .dropped(dropped)
  );

  assign txByte  = head.data;
  assign txBreak = head.brk;

endmodule

// File: rtl/dbg_cmd_chk.sv
module dbg_cmd_chk (
  input logic        clk,
  input logic        rstN,
  input logic        txValid,
  input logic        txTake,
  input logic [7:0]  txByte,
  input logic        txBreak,
  input logic        coreHalt,
  input logic [15:0] corePc,
  input logic [15:0] pcOut,
  input logic [5:0]  strobes,
  input logic        portOff,
  input logic        dropped
);

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes)); // R7

  AST_PORTOFF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    portOff |=> portOff); // R10

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    portOff |=> (strobes == 6'd0)); // R10

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txTake) |=> (txValid && $stable(txByte) && $stable(txBreak))); // R13

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    !dropped); // R13

  AST_HALT_PC: assert property (@(posedge clk) disable iff (!rstN)
    coreHalt |=> (pcOut == $past(corePc))); // R12

endmodule

bind dbg_cmd_top dbg_cmd_chk chk_i (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txTake(txTake),
  .txByte(txByte), .txBreak(txBreak), .coreHalt(coreHalt), .corePc(corePc),
  .pcOut(pcOut),
  .strobes({goMem, stepReg, execIr, resumeRun, stepOne, coreReset}),
  .portOff(portOff), .dropped(dropped)
);

// File: tb/dbg_cmd_top_tb_top.sv
module dbg_cmd_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxValid = 1'b0, rxBreak = 1'b0, txTake = 1'b1, coreHalt = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic [15:0] corePc = 16'h0000;
  logic txValid, txBreak, timersRun, goMem, stepReg, execIr, resumeRun, stepOne, coreReset, portOff;
  logic [7:0] txByte, ctlOut, flagOut;
  logic [15:0] pcOut, bpOut, irOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cmd_top dut_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte), .rxBreak(rxBreak),
    .txTake(txTake), .txValid(txValid), .txByte(txByte), .txBreak(txBreak),
    .coreHalt(coreHalt), .corePc(corePc), .pcOut(pcOut), .bpOut(bpOut), .irOut(irOut),
    .ctlOut(ctlOut), .flagOut(flagOut), .timersRun(timersRun), .goMem(goMem),
    .stepReg(stepReg), .execIr(execIr), .resumeRun(resumeRun), .stepOne(stepOne),
    .coreReset(coreReset), .portOff(portOff)
  );

  int nChk = 0, nFail = 0;
  bit done = 1'b0;
  string curReq = "R1";

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [15:0] mPc, mBp, mIr;
  logic [7:0]  mCtl, mFlag, mHi;
  logic        mAb, mOff;
  int          mSt, mSel;
  logic [5:0]  mStb;
  logic [8:0]  mQ[$];
  logic [8:0]  mPush[$];

  function automatic logic [15:0] mWord(int s);
    case (s)
      0: return mPc + (mAb ? 16'd1 : 16'd0);
      1: return mBp;
      2: return mIr;
      default: return 16'h9489;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPc = 0; mBp = 0; mIr = 0; mCtl = 0; mFlag = 0; mHi = 0;
      mAb = 0; mOff = 0; mSt = 0; mSel = 0; mStb = 0;
      mQ.delete();
    end else begin
      bit setAb, clrAb;
      logic [7:0] b;
      logic [15:0] w;
      setAb = 0; clrAb = 0; mStb = 0;
      mPush.delete();
      b = rxByte;
      if (mQ.size() > 0 && txTake) void'(mQ.pop_front());
      if (!mOff) begin
        if (rxBreak) begin
          mSt = 0; mPush.push_back(9'h055); setAb = 1;
        end else if (rxValid) begin
          if (mSt == 1) begin mHi = b; mSt = 2; end
          else if (mSt == 2) begin
            if (mSel == 0) begin mPc = {mHi, b}; clrAb = 1; end
            else if (mSel == 1) mBp = {mHi, b};
            else if (mSel == 2) mIr = {mHi, b};
            mSt = 0;
          end else if (mSt == 3) begin mCtl = b; mSt = 0; end
          else if (b[7:6] == 2'b11) begin
            if (b[5:4] == 0) mSt = 3;
            else if (b[5:4] == 1) begin mSel = int'(b[1:0]); mSt = 1; end
            else if (b[5:4] == 2) mPush.push_back({1'b0, mCtl});
            else begin
              w = mWord(int'(b[1:0]));
              mPush.push_back({1'b0, w[15:8]});
              mPush.push_back({1'b0, w[7:0]});
            end
          end else if (b[7:6] == 2'b01) mFlag = b;
          else if (b[7:6] == 2'b00) begin
            if (b[2:0] == 3'b111) begin
              mStb[0] = 1; setAb = 1;
              mPush.push_back(9'h000); mPush.push_back(9'h100); mPush.push_back(9'h055);
            end else if (b[2:0] == 3'b110) mOff = 1;
            else begin
              case (b)
                8'h20: begin mStb[5] = 1; clrAb = 1; end
                8'h21: begin mStb[4] = 1; clrAb = 1; end
                8'h23: begin mStb[3] = 1; clrAb = 1; end
                8'h30: begin mStb[2] = 1; clrAb = 1; end
                8'h31: begin mStb[1] = 1; clrAb = 1; end
                default: ;
              endcase
            end
          end
        end
      end
      if (coreHalt) begin
        mPc = corePc; setAb = 1;
        mPush.push_back(9'h100); mPush.push_back(9'h055);
      end
      if (setAb) mAb = 1; else if (clrAb) mAb = 0;
      foreach (mPush[i]) mQ.push_back(mPush[i]);
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(curReq, "pcOut", 32'(pcOut), 32'(mPc));
      chk(curReq, "bpOut", 32'(bpOut), 32'(mBp));
      chk(curReq, "irOut", 32'(irOut), 32'(mIr));
      chk(curReq, "ctlOut", 32'(ctlOut), 32'(mCtl));
      chk(curReq, "flagOut", 32'(flagOut), 32'(mFlag));
      chk(curReq, "timersRun", 32'(timersRun), 32'(!mFlag[5]));
      chk(curReq, "strobes", 32'({goMem, stepReg, execIr, resumeRun, stepOne, coreReset}), 32'(mStb));
      chk(curReq, "portOff", 32'(portOff), 32'(mOff));
      chk(curReq, "txValid", 32'(txValid), 32'(mQ.size() > 0));
      if (mQ.size() > 0) chk(curReq, "txHead", 32'({txBreak, txByte}), 32'(mQ[0]));
    end
  end

  // log of consumed queue entries
  logic [8:0] txLog[$];
  always @(posedge clk) if (rstN && txValid && txTake) txLog.push_back({txBreak, txByte});

  task automatic chkLog(string req, int n, logic [8:0] e0, logic [8:0] e1, logic [8:0] e2);
    logic [8:0] e[3];
    e[0] = e0; e[1] = e1; e[2] = e2;
    chk(req, "log size", 32'(txLog.size()), 32'(n));
    for (int i = 0; i < n && i < txLog.size(); i++) chk(req, "log entry", 32'(txLog[i]), 32'(e[i]));
    txLog.delete();
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendByte(logic [7:0] b);
    @(negedge clk); rxValid = 1'b1; rxByte = b;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic sendBreak();
    @(negedge clk); rxBreak = 1'b1;
    @(negedge clk); rxBreak = 1'b0;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    curReq = "R1";
    @(negedge clk);
    chk("R1", "pcOut", 32'(pcOut), 0);
    chk("R1", "timersRun", 32'(timersRun), 1);
    chk("R1", "txValid", 32'(txValid), 0);
    chk("R1", "portOff", 32'(portOff), 0);

    curReq = "R2";
    sendByte(8'hD0); sendByte(8'h12); sendByte(8'h34);
    chk("R2", "pc load", 32'(pcOut), 32'h1234);
    sendByte(8'hD1); sendByte(8'h56); sendByte(8'h78);
    sendByte(8'hD6); sendByte(8'h9A); sendByte(8'hBC);
    chk("R2", "ir via alias", 32'(irOut), 32'h9ABC);
    sendByte(8'hD3); sendByte(8'h11); sendByte(8'h22);
    chk("R2", "D3 no effect bp", 32'(bpOut), 32'h5678);
    chk("R2", "D3 no effect pc", 32'(pcOut), 32'h1234);
    idle(3); txLog.delete();

    curReq = "R3";
    sendByte(8'hF0); idle(3); chkLog("R3", 2, 9'h012, 9'h034, 0);
    sendByte(8'hF5); idle(3); chkLog("R3", 2, 9'h056, 9'h078, 0);
    sendByte(8'hFA); idle(3); chkLog("R3", 2, 9'h09A, 9'h0BC, 0);
    sendByte(8'hFF); idle(3); chkLog("R3", 2, 9'h094, 9'h089, 0);

    curReq = "R5";
    sendByte(8'hC2); sendByte(8'h05);
    chk("R5", "ctlOut", 32'(ctlOut), 32'h05);
    sendByte(8'hE7); idle(3); chkLog("R5", 1, 9'h005, 0, 0);

    curReq = "R6";
    sendByte(8'h66);
    chk("R6", "flagOut", 32'(flagOut), 32'h66);
    chk("R6", "timersRun off", 32'(timersRun), 0);
    sendByte(8'h46);
    chk("R6", "timersRun on", 32'(timersRun), 1);

    curReq = "R7";
    sendByte(8'h20); chk("R7", "goMem", 32'(goMem), 1);
    sendByte(8'h21); chk("R7", "stepReg", 32'(stepReg), 1);
    sendByte(8'h23); chk("R7", "execIr", 32'(execIr), 1);
    sendByte(8'h30); chk("R7", "resumeRun", 32'(resumeRun), 1);
    sendByte(8'h31); chk("R7", "stepOne", 32'(stepOne), 1);
    @(negedge clk); chk("R7", "pulse ends", 32'(stepOne), 0);

    curReq = "R4";
    sendBreak(); idle(2); chkLog("R4", 1, 9'h055, 0, 0);
    sendByte(8'hF0); idle(3); chkLog("R4", 2, 9'h012, 9'h035, 0);
    sendByte(8'hD0); sendByte(8'h00); sendByte(8'h10);
    sendByte(8'hF0); idle(3); chkLog("R4", 2, 9'h000, 9'h010, 0);

    curReq = "R9";
    sendByte(8'hD1); sendByte(8'hAA); sendBreak(); idle(2);
    chk("R9", "bp kept", 32'(bpOut), 32'h5678);
    chkLog("R9", 1, 9'h055, 0, 0);
    sendByte(8'hF1); idle(3); chkLog("R9", 2, 9'h056, 9'h078, 0);
    @(negedge clk); rxBreak = 1'b1; rxValid = 1'b1; rxByte = 8'h07;
    @(negedge clk); rxBreak = 1'b0; rxValid = 1'b0;
    chk("R9", "byte dropped", 32'(coreReset), 0);
    idle(2); chkLog("R9", 1, 9'h055, 0, 0);

    curReq = "R12";
    sendByte(8'h30);
    @(negedge clk); coreHalt = 1'b1; corePc = 16'h0ABC;
    @(negedge clk); coreHalt = 1'b0;
    chk("R12", "pc from core", 32'(pcOut), 32'h0ABC);
    idle(3); chkLog("R12", 2, 9'h100, 9'h055, 0);
    sendByte(8'hF0); idle(3); chkLog("R12", 2, 9'h00A, 9'h0BD, 0);

    curReq = "R8";
    sendByte(8'h23);
    sendByte(8'h2F); chk("R8", "coreReset", 32'(coreReset), 1);
    idle(4); chkLog("R8", 3, 9'h000, 9'h100, 9'h055);
    sendByte(8'hF0); idle(3); chkLog("R8", 2, 9'h00A, 9'h0BD, 0);

    curReq = "R11";
    sendByte(8'h83); sendByte(8'hA0); sendByte(8'h22); sendByte(8'h05); sendByte(8'h32);
    idle(3);
    chkLog("R11", 0, 0, 0, 0);
    chk("R11", "pc kept", 32'(pcOut), 32'h0ABC);
    chk("R11", "ctl kept", 32'(ctlOut), 32'h05);

    curReq = "R13";
    @(negedge clk); txTake = 1'b0;
    sendByte(8'hF3); sendByte(8'hE0); idle(4);
    chk("R13", "held valid", 32'(txValid), 1);
    chk("R13", "held head", 32'({txBreak, txByte}), 32'h094);
    chkLog("R13", 0, 0, 0, 0);
    txTake = 1'b1; idle(5);
    chkLog("R13", 3, 9'h094, 9'h089, 9'h005);

    curReq = "R10";
    sendByte(8'h3E);
    chk("R10", "portOff", 32'(portOff), 1);
    sendByte(8'hF0); sendBreak(); sendByte(8'hD0); sendByte(8'h11); sendByte(8'h11);
    sendByte(8'h30); idle(3);
    chkLog("R10", 0, 0, 0, 0);
    chk("R10", "pc kept", 32'(pcOut), 32'h0ABC);
    chk("R10", "still off", 32'(portOff), 1);

    idle(2);
    finishRun();
  end

endmodule